// File: doc/BRIEF.md
# Configuration-Space Access Controller

This block sits between a big-endian system bus and a simplified PCI master port and turns word accesses that land in a 64 KB configuration window into PCI configuration cycles. The window offset supplies the device/function number and the dword register number; the target bus number is held in a control register that software programs before it touches the window. Bus 0 is addressed with type 0 cycles and every other bus with type 1 cycles.

A system-bus access that hits the window stalls until the PCI side reports completion. Only one configuration access is in flight at any time. Completion and failure are not returned as a bus error: they are recorded in two sticky status bits that software clears by writing one before it issues the next access. A failed read returns all ones. Data crosses the block byte-swapped, because configuration data on the PCI side is little-endian.

Top module: `cfg_window_ctrl`

## Requirements
- R1: After reset, pm_req and sb_ready are low, the bus field of the control register reads 0 and the status register reads 0.
- R2: For an access inside the window, pm_devfn carries window offset bits 15:8 and pm_regnum carries offset bits 7:2. Offset bits 1:0 have no effect. The fields stay stable while pm_req is high.
- R3: pm_bus carries the control register field at bits 23:16, sampled when the access is accepted. A later control write does not change it during the access. pm_type1 is high exactly when pm_bus is nonzero.
- R4: An access whose upper address bits (above bit 15) do not equal those of WIN_BASE starts no PCI cycle. sb_ready rises on the next cycle with sb_rdata equal to 0, and the status bits stay unchanged.
- R5: pm_req rises one cycle after a window hit is accepted and falls after the cycle in which pm_done is high. sb_ready is high for exactly one cycle, which is the cycle after that one. sb_ready and pm_req are never high together.
- R6: For a write, pm_write is high and pm_wdata holds sb_wdata with its four bytes in reverse order (byte 0 swapped with byte 3, byte 1 with byte 2).
- R7: A read that completes without error returns pm_rdata byte-reversed on sb_rdata. A read that completes with pm_err returns 0xFFFFFFFF.
- R8: Status bit 20 (done) sets on every completion of a PCI cycle. Status bit 19 (fail) sets on a completion that has pm_err high.
- R9: A status write (reg_sel=1) with a one in bit 20 or bit 19 clears that bit, and a zero in that bit leaves it unchanged. A completion in the same cycle as a clear wins, so the bit is set afterwards.
- R10: A completion may be delayed for any number of cycles. Until pm_done, pm_req stays high and sb_ready stays low.
- R11: Only control bits 23:16 are writable. All other control bits read 0, and status bits other than 20 and 19 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sb_req | input | 1 | System-bus access request, held until sb_ready |
| sb_write | input | 1 | 1 = write, 0 = read |
| sb_addr | input | ADDR_W | System-bus byte address |
| sb_wdata | input | 32 | Write data (big-endian) |
| sb_ready | output | 1 | One-cycle access completion |
| sb_rdata | output | 32 | Read data, valid with sb_ready |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| pm_req | output | 1 | Configuration cycle request to PCI master |
| pm_write | output | 1 | Cycle direction |
| pm_type1 | output | 1 | 1 = type 1 cycle, 0 = type 0 cycle |
| pm_bus | output | 8 | Target bus number |
| pm_devfn | output | 8 | Device/function number |
| pm_regnum | output | 6 | Dword register number |
| pm_wdata | output | 32 | Write data (little-endian) |
| pm_done | input | 1 | Cycle completed (one cycle) |
| pm_err | input | 1 | Cycle failed, valid with pm_done |
| pm_rdata | input | 32 | Read data (little-endian), valid with pm_done |

## Verification
The bench sweeps all 256 device/function values and all 64 register numbers. It gives each access nonzero low address bits, so a decoder that shifts the fields by one bit or leaks bits 1:0 returns the wrong register. Bus numbers 0, 1, 0x80 and 0xFF cover the type 0 and type 1 boundary, and a control write made during an access exposes a design that forwards the live register instead of the value it sampled. Completion delays run from zero to forty cycles, errors are mixed with good reads, and a clear is made in the same cycle as a completion. These catch early ready pulses, an error read that leaks swapped data, and a clear that wins over a completion and loses the done indication. A miss outside the window must leave pm_req low and the status untouched.

// File: rtl/cfg_win_pkg.sv
package cfg_win_pkg;

  parameter int WORD_W       = 32;
  parameter int BUS_W        = 8;
  parameter int DEVFN_W      = 8;
  parameter int REGNUM_W     = 6;
  parameter int OFF_W        = 16;
  parameter int CTRL_BUS_LSB = 16;
  parameter int STAT_VLD_BIT = 20;
  parameter int STAT_ERR_BIT = 19;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BUSY = 2'd1,
    SEQ_RESP = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic [DEVFN_W-1:0]  devfn;
    logic [REGNUM_W-1:0] regnum;
  } cfg_loc_t;

  // Reverse byte order between the big-endian system side and the PCI side.
  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Offset bits 15:2 split into device/function and register number.
  function automatic cfg_loc_t split_offset(input logic [OFF_W-1:2] off);
    cfg_loc_t l;
    l.devfn  = off[OFF_W-1:8];
    l.regnum = off[7:2];
    return l;
  endfunction

  // Bus 0 is local (type 0); any other bus is behind a bridge (type 1).
  function automatic logic needs_type1(input logic [BUS_W-1:0] bus);
    return |bus;
  endfunction

endpackage

// File: rtl/cfg_win_decode.sv
module cfg_win_decode
  import cfg_win_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output cfg_loc_t          loc
);

  localparam int TAG_W = ADDR_W - OFF_W;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:OFF_W];

  logic [TAG_W-1:0] addr_tag;
  logic [1:0]       unused_byte_sel;

  assign addr_tag        = addr[ADDR_W-1:OFF_W];
  assign hit             = (addr_tag == WIN_TAG);
  assign loc             = split_offset(addr[OFF_W-1:2]);
  assign unused_byte_sel = addr[1:0];

endmodule

// File: rtl/cfg_win_regs.sv
module cfg_win_regs
  import cfg_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              set_vld,
  input  logic              set_err,
  output logic              clr_vld,
  output logic              clr_err,
  output logic [BUS_W-1:0]  bus_sel,
  output logic              stat_vld,
  output logic              stat_err,
  output logic [WORD_W-1:0] reg_rdata
);

  logic             ctrl_we;
  logic             stat_we;
  logic [BUS_W-1:0] bus_q;
  logic             vld_q;
  logic             err_q;
  logic             unused_wbits;

  assign ctrl_we = reg_wr && !reg_sel;
  assign stat_we = reg_wr &&  reg_sel;
  assign clr_vld = stat_we && reg_wdata[STAT_VLD_BIT];
  assign clr_err = stat_we && reg_wdata[STAT_ERR_BIT];
  assign unused_wbits = ^{reg_wdata[WORD_W-1:CTRL_BUS_LSB+BUS_W], reg_wdata[CTRL_BUS_LSB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
    end else if (ctrl_we) begin
      bus_q <= reg_wdata[CTRL_BUS_LSB +: BUS_W];
    end
  end

  // Sticky bits: a completion outranks a write-one clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (set_vld)      vld_q <= 1'b1;
      else if (clr_vld) vld_q <= 1'b0;
      if (set_err)      err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      reg_rdata[STAT_VLD_BIT] = vld_q;
      reg_rdata[STAT_ERR_BIT] = err_q;
    end else begin
      reg_rdata[CTRL_BUS_LSB +: BUS_W] = bus_q;
    end
  end

  assign bus_sel  = bus_q;
  assign stat_vld = vld_q;
  assign stat_err = err_q;

endmodule

// File: rtl/cfg_win_seq.sv
module cfg_win_seq
  import cfg_win_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sb_req,
  input  logic                sb_write,
  input  logic [WORD_W-1:0]   sb_wdata,
  input  logic                hit,
  input  cfg_loc_t            loc,
  input  logic [BUS_W-1:0]    bus_sel,
  input  logic                pm_done,
  input  logic                pm_err,
  input  logic [WORD_W-1:0]   pm_rdata,
  output logic                pm_req,
  output logic                pm_write,
  output logic                pm_type1,
  output logic [BUS_W-1:0]    pm_bus,
  output logic [DEVFN_W-1:0]  pm_devfn,
  output logic [REGNUM_W-1:0] pm_regnum,
  output logic [WORD_W-1:0]   pm_wdata,
  output logic                sb_ready,
  output logic [WORD_W-1:0]   sb_rdata,
  output logic                evt_accept,
  output logic                evt_miss,
  output logic                evt_complete
);

  seq_state_t          state_q;
  logic                write_q;
  logic                type1_q;
  logic [BUS_W-1:0]    bus_q;
  cfg_loc_t            loc_q;
  logic [WORD_W-1:0]   wdata_q;
  logic [WORD_W-1:0]   rdata_q;
  logic [WORD_W-1:0]   rdata_next;

  assign evt_accept   = (state_q == SEQ_IDLE) && sb_req &&  hit;
  assign evt_miss     = (state_q == SEQ_IDLE) && sb_req && !hit;
  assign evt_complete = (state_q == SEQ_BUSY) && pm_done;

  always_comb begin
    if (pm_err)        rdata_next = '1;
    else if (write_q)  rdata_next = '0;
    else               rdata_next = swap_bytes(pm_rdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (evt_accept)    state_q <= SEQ_BUSY;
          else if (evt_miss) state_q <= SEQ_RESP;
        end
        SEQ_BUSY: if (pm_done) state_q <= SEQ_RESP;
        SEQ_RESP: state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  // Cycle attributes are latched at acceptance and held for the whole cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      type1_q <= 1'b0;
      bus_q   <= '0;
      loc_q   <= '0;
      wdata_q <= '0;
    end else if (evt_accept) begin
      write_q <= sb_write;
      type1_q <= needs_type1(bus_sel);
      bus_q   <= bus_sel;
      loc_q   <= loc;
      wdata_q <= swap_bytes(sb_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (evt_miss) begin
      rdata_q <= '0;
    end else if (evt_complete) begin
      rdata_q <= rdata_next;
    end
  end

  assign pm_req    = (state_q == SEQ_BUSY);
  assign pm_write  = write_q;
  assign pm_type1  = type1_q;
  assign pm_bus    = bus_q;
  assign pm_devfn  = loc_q.devfn;
  assign pm_regnum = loc_q.regnum;
  assign pm_wdata  = wdata_q;
  assign sb_ready  = (state_q == SEQ_RESP);
  assign sb_rdata  = rdata_q;

endmodule

// File: rtl/cfg_window_ctrl.sv
module cfg_window_ctrl
  import cfg_win_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sb_req,
  input  logic                sb_write,
  input  logic [ADDR_W-1:0]   sb_addr,
  input  logic [WORD_W-1:0]   sb_wdata,
  output logic                sb_ready,
  output logic [WORD_W-1:0]   sb_rdata,
  input  logic                reg_wr,
  input  logic                reg_sel,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                pm_req,
  output logic                pm_write,
  output logic                pm_type1,
  output logic [BUS_W-1:0]    pm_bus,
  output logic [DEVFN_W-1:0]  pm_devfn,
  output logic [REGNUM_W-1:0] pm_regnum,
  output logic [WORD_W-1:0]   pm_wdata,
  input  logic                pm_done,
  input  logic                pm_err,
  input  logic [WORD_W-1:0]   pm_rdata
);

  logic             win_hit;
  cfg_loc_t         win_loc;
  logic [BUS_W-1:0] bus_sel;
  logic             evt_accept;
  logic             evt_miss;
  logic             evt_complete;
  logic             evt_fail;
  logic             evt_clr_vld;
  logic             evt_clr_err;
  logic             stat_vld;
  logic             stat_err;

  assign evt_fail = evt_complete && pm_err;

  cfg_win_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE)
  ) u_decode (
    .addr (sb_addr),
    .hit  (win_hit),
    .loc  (win_loc)
  );

  cfg_win_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .set_vld   (evt_complete),
    .set_err   (evt_fail),
    .clr_vld   (evt_clr_vld),
    .clr_err   (evt_clr_err),
    .bus_sel   (bus_sel),
    .stat_vld  (stat_vld),
    .stat_err  (stat_err),
    .reg_rdata (reg_rdata)
  );

  cfg_win_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .sb_req       (sb_req),
    .sb_write     (sb_write),
    .sb_wdata     (sb_wdata),
    .hit          (win_hit),
    .loc          (win_loc),
    .bus_sel      (bus_sel),
    .pm_done      (pm_done),
    .pm_err       (pm_err),
    .pm_rdata     (pm_rdata),
    .pm_req       (pm_req),
    .pm_write     (pm_write),
    .pm_type1     (pm_type1),
    .pm_bus       (pm_bus),
    .pm_devfn     (pm_devfn),
    .pm_regnum    (pm_regnum),
    .pm_wdata     (pm_wdata),
    .sb_ready     (sb_ready),
    .sb_rdata     (sb_rdata),
    .evt_accept   (evt_accept),
    .evt_miss     (evt_miss),
    .evt_complete (evt_complete)
  );

endmodule

// File: rtl/cfg_window_chk.sv
module cfg_window_chk
  import cfg_win_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                pm_req,
  input logic                pm_done,
  input logic                pm_err,
  input logic                pm_write,
  input logic                pm_type1,
  input logic [BUS_W-1:0]    pm_bus,
  input logic [DEVFN_W-1:0]  pm_devfn,
  input logic [REGNUM_W-1:0] pm_regnum,
  input logic                sb_ready,
  input logic [WORD_W-1:0]   sb_rdata,
  input logic                evt_miss,
  input logic                evt_complete,
  input logic                evt_clr_vld,
  input logic                stat_vld,
  input logic                stat_err
);

  AST_TYPE_MATCHES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req |-> (pm_type1 == (pm_bus != '0))); // R3

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req && !pm_done |=> $stable(pm_bus) && $stable(pm_devfn) && $stable(pm_regnum)); // R2

  AST_MISS_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_miss |=> sb_ready && !pm_req && (sb_rdata == '0)); // R4

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_complete |=> sb_ready && !pm_req); // R5

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sb_ready |=> !sb_ready); // R5

  AST_ERR_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    evt_complete && pm_err && !pm_write |=> sb_rdata == '1); // R7

  AST_DONE_SETS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_complete |=> stat_vld); // R8

  AST_FAIL_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_complete && pm_err |=> stat_err); // R8

  AST_W1C_CLEARS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clr_vld && !evt_complete |=> !stat_vld); // R9

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req && !pm_done |=> pm_req && !sb_ready); // R10

endmodule

bind cfg_window_ctrl cfg_window_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pm_req       (pm_req),
  .pm_done      (pm_done),
  .pm_err       (pm_err),
  .pm_write     (pm_write),
  .pm_type1     (pm_type1),
  .pm_bus       (pm_bus),
  .pm_devfn     (pm_devfn),
  .pm_regnum    (pm_regnum),
  .sb_ready     (sb_ready),
  .sb_rdata     (sb_rdata),
  .evt_miss     (evt_miss),
  .evt_complete (evt_complete),
  .evt_clr_vld  (evt_clr_vld),
  .stat_vld     (stat_vld),
  .stat_err     (stat_err)
);

// File: tb/cfg_window_ctrl_bench.sv
`timescale 1ns/1ps
module cfg_window_ctrl_bench;

  localparam logic [31:0] BASE = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sb_req = 1'b0, sb_write = 1'b0;
  logic [31:0] sb_addr = '0, sb_wdata = '0;
  logic        sb_ready;
  logic [31:0] sb_rdata;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pm_req, pm_write, pm_type1;
  logic [7:0]  pm_bus, pm_devfn;
  logic [5:0]  pm_regnum;
  logic [31:0] pm_wdata;
  logic        pm_done = 1'b0, pm_err = 1'b0;
  logic [31:0] pm_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  cfg_window_ctrl #(.ADDR_W(32), .WIN_BASE(BASE)) u_cfg_window_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sb_req(sb_req), .sb_write(sb_write), .sb_addr(sb_addr), .sb_wdata(sb_wdata),
    .sb_ready(sb_ready), .sb_rdata(sb_rdata),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pm_req(pm_req), .pm_write(pm_write), .pm_type1(pm_type1), .pm_bus(pm_bus),
    .pm_devfn(pm_devfn), .pm_regnum(pm_regnum), .pm_wdata(pm_wdata),
    .pm_done(pm_done), .pm_err(pm_err), .pm_rdata(pm_rdata)
  );

  function automatic logic [31:0] rev4(input logic [31:0] w);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = w[8*(3-i) +: 8];
    return r;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic stat_read(output logic [31:0] v);
    reg_sel = 1'b1; #0.1; v = reg_rdata;
  endtask

  // One window access with a modelled PCI completion after dly wait cycles.
  task automatic do_acc(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                        input logic [7:0] bus, input int dly, input bit perr,
                        input logic [31:0] prd, input bit clr_same, input bit chg_bus);
    logic [31:0] st;
    @(negedge clk);
    reg_write(1'b0, {8'h00, bus, 16'h0000});
    sb_req = 1'b1; sb_write = wr; sb_addr = addr; sb_wdata = wd;
    @(negedge clk);
    chk({31'b0, pm_req},   32'd1, "R5 pm_req after accept");
    chk({31'b0, sb_ready}, 32'd0, "R5 no early ready");
    chk({24'b0, pm_devfn}, {24'b0, addr[15:8]}, "R2 devfn");
    chk({26'b0, pm_regnum}, {26'b0, addr[7:2]}, "R2 regnum");
    chk({24'b0, pm_bus},   {24'b0, bus}, "R3 bus");
    chk({31'b0, pm_type1}, {31'b0, bus != 8'h00}, "R3 type");
    chk({31'b0, pm_write}, {31'b0, wr}, "R6 direction");
    if (wr) chk(pm_wdata, rev4(wd), "R6 write swap");
    if (chg_bus) begin
      reg_write(1'b0, {8'h00, ~bus, 16'h0000});
      chk({24'b0, pm_bus}, {24'b0, bus}, "R3 bus held");
    end
    for (int d = 0; d < dly; d++) begin
      @(negedge clk);
      chk({30'b0, pm_req, sb_ready}, 32'd2, "R10 waiting");
    end
    pm_done = 1'b1; pm_err = perr; pm_rdata = prd;
    if (clr_same) begin reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0018_0000; end
    @(negedge clk);
    pm_done = 1'b0; pm_err = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    chk({30'b0, sb_ready, pm_req}, 32'd2, "R5 ready after done");
    if (!wr) chk(sb_rdata, perr ? 32'hFFFF_FFFF : rev4(prd), "R7 read data");
    sb_req = 1'b0;
    stat_read(st);
    chk({30'b0, st[20], st[19]}, {30'b0, 1'b1, perr}, clr_same ? "R9 set wins" : "R8 status");
    chk(st & ~32'h0018_0000, 32'd0, "R11 status other bits");
    reg_write(1'b1, 32'h0000_0000);
    stat_read(st);
    chk({31'b0, st[20]}, 32'd1, "R9 zero write keeps");
    reg_write(1'b1, 32'h0018_0000);
    stat_read(st);
    chk(st, 32'd0, "R9 w1c");
    chk({31'b0, sb_ready}, 32'd0, "R5 single ready");
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk({30'b0, pm_req, sb_ready}, 32'd0, "R1 outputs idle");
    reg_sel = 1'b0; #0.1; chk(reg_rdata, 32'd0, "R1 control");
    stat_read(v); chk(v, 32'd0, "R1 status");
    rst_n = 1'b1;
    @(negedge clk);
    reg_write(1'b0, 32'hFFFF_FFFF);
    reg_sel = 1'b0; #0.1; chk(reg_rdata, 32'h00FF_0000, "R11 control mask");
    reg_write(1'b0, 32'h0);
    // Device/function sweep on bus 0, mixed delays and errors.
    for (int f = 0; f < 256; f++) begin
      logic [5:0] rn;
      rn = f[5:0] ^ 6'h15;
      do_acc(1'b0, BASE | (f << 8) | (rn << 2) | (f & 3), 32'h0,
             8'h00, f % 4, (f % 7) == 3, 32'h1122_3300 | f, 1'b0, 1'b0);
    end
    // Register-number sweep, writes on a type 1 bus, low byte bits nonzero.
    for (int r = 0; r < 64; r++) begin
      do_acc(1'b1, BASE | 32'h3C00 | (r << 2) | (r % 4), 32'hA0B1_C200 | r,
             8'h5A, r % 3, (r % 9) == 5, 32'h0, 1'b0, 1'b0);
    end
    do_acc(1'b0, BASE | 32'h0804, 32'h0, 8'h01, 1, 1'b0, 32'hDEAD_BEEF, 1'b0, 1'b0);
    do_acc(1'b1, BASE | 32'hFFFC, 32'h0102_0304, 8'h80, 0, 1'b0, 32'h0, 1'b0, 1'b0);
    do_acc(1'b0, BASE | 32'h1234, 32'h0, 8'hFF, 2, 1'b1, 32'h5555_AAAA, 1'b0, 1'b1);
    do_acc(1'b0, BASE | 32'h2040, 32'h0, 8'h00, 40, 1'b0, 32'h89AB_CDEF, 1'b0, 1'b0);
    do_acc(1'b1, BASE | 32'h2044, 32'h7777_0000, 8'h03, 3, 1'b0, 32'h0, 1'b1, 1'b0);
    do_acc(1'b0, BASE | 32'h2048, 32'h0, 8'h03, 0, 1'b1, 32'h1234_5678, 1'b1, 1'b0);
    // Misses outside the window (R4).
    for (int m = 0; m < 3; m++) begin
      logic [31:0] a;
      a = (m == 0) ? 32'h0002_0010 : (m == 1) ? 32'h0000_FFFC : 32'h8001_0000;
      @(negedge clk);
      sb_req = 1'b1; sb_write = m[0]; sb_addr = a; sb_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      chk({30'b0, sb_ready, pm_req}, 32'd2, "R4 miss ready no cycle");
      chk(sb_rdata, 32'd0, "R4 miss data");
      sb_req = 1'b0;
      stat_read(v);
      chk(v, 32'd0, "R4 status unchanged");
      @(negedge clk);
      chk({31'b0, pm_req}, 32'd0, "R4 no late cycle");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule